// File: doc/BRIEF.md
# Linear Pointer Data Port

This block gives a processor register-mapped, indirect access to any byte of a 17-bit extended memory. The access does not depend on which program page is executing. Software first loads a pointer through three byte-wide pointer registers (low, middle, high). It then reads or writes one of three data aliases. Each alias access becomes a single byte request on a simple memory request/acknowledge port, at the address the pointer holds.

The three aliases perform the same memory access. They differ only in what happens to the pointer afterwards:
- The stay alias leaves the pointer where it is.
- The byte-step alias adds one to it.
- The word-step alias also adds one. It is meant for moving a 16-bit quantity as two back-to-back byte accesses.

A data access stretches the bus cycle with a wait signal until memory acknowledges. The pointer advances on the clock edge that ends the access. The bus master keeps address and strobe steady while wait is high, and releases the strobe after the first cycle in which wait is low.

Register offsets on the bus address:

| Offset | Register |
|--------|----------|
| 0 | pointer low |
| 1 | pointer middle |
| 2 | pointer high |
| 3 | stay alias |
| 4 | byte-step alias |
| 5 | word-step alias |
| 6, 7 | reserved |

Top module: `lptr_port`

## Requirements
- R1: While reset is high and in the first cycle after it, the pointer is 0, `mem_req` is low and `bus_wait` is low.
- R2: A write to offset 0, 1 or 2 loads the pointer bits [7:0], [15:8] or [16] respectively, and a read of the same offset returns them. The high register implements only bit 0, and its bits 7:1 read as 0.
- R3: A read or write to any data alias (offset 3, 4 or 5) raises `mem_req` with `mem_addr` equal to the pointer. It drives `mem_we` high for a write with `mem_wdata` equal to the bus data, and low for a read. `mem_req` is held until the cycle in which `mem_ack` is high.
- R4: During a data alias access, `bus_wait` is high from the strobe cycle until the cycle in which memory acknowledges. In that cycle `bus_wait` is low and, for a read, `bus_rdata` equals `mem_rdata`. With an acknowledge latency of L idle request cycles, the master sees exactly L+2 wait cycles.
- R5: An access through the stay alias (offset 3) leaves the pointer unchanged.
- R6: An access through the byte-step alias (offset 4) adds one to the pointer on the edge that completes the access.
- R7: An access through the word-step alias (offset 5) also adds one to the pointer, so two consecutive accesses touch two consecutive bytes, with the carry crossing byte-register boundaries.
- R8: Pointer advance wraps from 0x1FFFF to 0x00000.
- R9: Offsets 6 and 7 read as 0, and writes to them change neither the pointer nor memory.
- R10: While `mem_req` is high and not yet acknowledged, `mem_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_wait | output | 1 | Stretches the bus cycle during a data access |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W (17) | Byte address; always shows the pointer |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Memory acknowledge, one cycle per request |
| mem_rdata | input | 8 | Byte read, valid with `mem_ack` |

## Verification
The bench builds the block with the default 17-bit pointer. With that width, the one-bit high register and the wrap from 0x1FFFF to zero can be reached by loading the pointer directly. Its memory responder is configured with acknowledge latencies from zero to three cycles, so the exact length of the wait stretch is checked in more than one case. Word-step writes placed just below a 256-byte boundary make the carry ripple from the low register into the middle one.

// File: rtl/lptr_pkg.sv
package lptr_pkg;

    localparam int unsigned REG_AW    = 3;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned PTR_BYTES = 3;

    localparam logic [REG_AW-1:0] OFF_PTR_LO   = 3'd0;
    localparam logic [REG_AW-1:0] OFF_PTR_MID  = 3'd1;
    localparam logic [REG_AW-1:0] OFF_PTR_HI   = 3'd2;
    localparam logic [REG_AW-1:0] OFF_DAT_STAY = 3'd3;
    localparam logic [REG_AW-1:0] OFF_DAT_BYTE = 3'd4;
    localparam logic [REG_AW-1:0] OFF_DAT_WORD = 3'd5;

    // Pointer advance policy attached to a data alias
    typedef enum logic [1:0] {
        ADV_NONE = 2'd0,
        ADV_BYTE = 2'd1,
        ADV_WORD = 2'd2
    } adv_e;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_WAIT = 1'b1
    } xf_state_e;

    typedef struct packed {
        logic       ptr_hit;
        logic [1:0] ptr_sel;
        logic       dat_hit;
        adv_e       adv;
    } regsel_t;

    function automatic logic [1:0] adv_amount(adv_e a);
        logic [1:0] amt;
        case (a)
            ADV_BYTE: amt = 2'd1;
            ADV_WORD: amt = 2'd1;
            default:  amt = 2'd0;
        endcase
        return amt;
    endfunction

endpackage

// File: rtl/lptr_decode.sv
module lptr_decode
    import lptr_pkg::*;
(
    input  logic [REG_AW-1:0] off,
    output regsel_t           sel
);

    always_comb begin
        sel         = '0;
        sel.adv     = ADV_NONE;
        case (off)
            OFF_PTR_LO: begin
                sel.ptr_hit = 1'b1;
                sel.ptr_sel = 2'd0;
            end
            OFF_PTR_MID: begin
                sel.ptr_hit = 1'b1;
                sel.ptr_sel = 2'd1;
            end
            OFF_PTR_HI: begin
                sel.ptr_hit = 1'b1;
                sel.ptr_sel = 2'd2;
            end
            OFF_DAT_STAY: begin
                sel.dat_hit = 1'b1;
                sel.adv     = ADV_NONE;
            end
            OFF_DAT_BYTE: begin
                sel.dat_hit = 1'b1;
                sel.adv     = ADV_BYTE;
            end
            OFF_DAT_WORD: begin
                sel.dat_hit = 1'b1;
                sel.adv     = ADV_WORD;
            end
            default: begin
                sel.ptr_hit = 1'b0;
                sel.dat_hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lptr_pointer.sv
module lptr_pointer
    import lptr_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              inc_en,
    input  logic [1:0]        inc_amt,
    input  logic [1:0]        rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0]                 ptr_next;
    logic [PTR_BYTES-1:0][BYTE_W-1:0]  byte_view;

    assign ptr_next = ptr + ADDR_W'(inc_amt);

    // One segment per byte register; the top one is as narrow as ADDR_W leaves it
    for (genvar b = 0; b < PTR_BYTES; b++) begin : g_seg
        localparam int unsigned LO  = b * BYTE_W;
        localparam int unsigned TOP = (LO + BYTE_W > ADDR_W) ? ADDR_W : LO + BYTE_W;
        localparam int unsigned W   = TOP - LO;

        logic [W-1:0] seg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                seg_q <= '0;
            end else if (wr_en && (wr_sel == 2'(b))) begin
                seg_q <= wr_data[W-1:0];
            end else if (inc_en) begin
                seg_q <= ptr_next[TOP-1:LO];
            end
        end

        assign ptr[TOP-1:LO] = seg_q;
        assign byte_view[b]  = BYTE_W'(seg_q);
    end

    assign rd_data = (int'(rd_sel) < PTR_BYTES) ? byte_view[rd_sel] : '0;

endmodule

// File: rtl/lptr_xfer.sv
module lptr_xfer
    import lptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_we,
    input  logic [BYTE_W-1:0] start_wdata,
    input  adv_e              start_adv,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              idle,
    output logic              done,
    output adv_e              done_adv
);

    xf_state_e         state_q;
    logic              we_q;
    logic [BYTE_W-1:0] wdata_q;
    adv_e              adv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XF_IDLE;
            we_q    <= 1'b0;
            wdata_q <= '0;
            adv_q   <= ADV_NONE;
        end else begin
            case (state_q)
                XF_IDLE: begin
                    if (start) begin
                        state_q <= XF_WAIT;
                        we_q    <= start_we;
                        wdata_q <= start_wdata;
                        adv_q   <= start_adv;
                    end
                end
                XF_WAIT: begin
                    if (mem_ack) begin
                        state_q <= XF_IDLE;
                    end
                end
                default: state_q <= XF_IDLE;
            endcase
        end
    end

    assign mem_req   = (state_q == XF_WAIT);
    assign mem_we    = we_q;
    assign mem_wdata = wdata_q;
    assign idle      = (state_q == XF_IDLE);
    assign done      = mem_req && mem_ack;
    assign done_adv  = adv_q;

endmodule

// File: rtl/lptr_port.sv
module lptr_port
    import lptr_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_wait,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata
);

    regsel_t           sel;
    logic              data_req;
    logic              xf_idle;
    logic              xf_done;
    adv_e              xf_adv;
    logic [BYTE_W-1:0] ptr_rd;
    logic [ADDR_W-1:0] ptr;

    lptr_decode u_dec (
        .off (bus_addr),
        .sel (sel)
    );

    assign data_req = sel.dat_hit && (bus_rd || bus_wr);

    lptr_xfer u_xfer (
        .clk         (clk),
        .rst         (rst),
        .start       (data_req && xf_idle),
        .start_we    (bus_wr),
        .start_wdata (bus_wdata),
        .start_adv   (sel.adv),
        .mem_ack     (mem_ack),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .idle        (xf_idle),
        .done        (xf_done),
        .done_adv    (xf_adv)
    );

    lptr_pointer #(
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr && sel.ptr_hit),
        .wr_sel  (sel.ptr_sel),
        .wr_data (bus_wdata),
        .inc_en  (xf_done),
        .inc_amt (adv_amount(xf_adv)),
        .rd_sel  (sel.ptr_sel),
        .rd_data (ptr_rd),
        .ptr     (ptr)
    );

    assign mem_addr = ptr;
    assign bus_wait = data_req && !xf_done;

    always_comb begin
        if (sel.ptr_hit) begin
            bus_rdata = ptr_rd;
        end else if (sel.dat_hit && xf_done) begin
            bus_rdata = mem_rdata;
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/lptr_port_chk.sv
module lptr_port_chk
    import lptr_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              bus_wait,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);

    localparam int unsigned HI_USED = ADDR_W - (PTR_BYTES - 1) * BYTE_W;

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!mem_req && !bus_wait && mem_addr == '0));

    // R2
    a_r2_hi_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_PTR_HI) |-> ((bus_rdata >> HI_USED) == '0));

    // R3
    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    // R4
    a_r4_wait_while_pending: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |-> bus_wait);

    a_r4_release_on_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |-> !bus_wait);

    // R5
    a_r5_stay_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && bus_addr == OFF_DAT_STAY) |=> $stable(mem_addr));

    // R6, R7, R8: both stepping aliases add one, modulo the pointer width
    a_r6_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && (bus_addr == OFF_DAT_BYTE || bus_addr == OFF_DAT_WORD))
        |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R9
    a_r9_reserved_no_effect: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr > OFF_DAT_WORD) |=> $stable(mem_addr));

    // R10
    a_r10_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

endmodule

bind lptr_port lptr_port_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .bus_wait  (bus_wait),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/lptr_port_tb_top.sv
`timescale 1ns/1ps
module lptr_port_tb_top;

    localparam int unsigned AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          bus_wait;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_ack = 1'b0;
    logic [7:0]    mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    lptr_port #(.ADDR_W(AW)) dut_i (
        .clk (clk), .rst (rst),
        .bus_addr (bus_addr), .bus_rd (bus_rd), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_wait (bus_wait),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata)
    );

    // ---------------- memory responder ----------------
    logic [7:0] store [int];
    int lat_cfg = 0;
    int lat_cnt = 0;

    function automatic logic [7:0] fill_byte(int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'(a >> 16);
    endfunction

    function automatic logic [7:0] peek(int a);
        if (store.exists(a)) return store[a];
        return fill_byte(a);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= lat_cfg;
        end else if (mem_req) begin
            if (lat_cnt == 0) begin
                mem_ack   <= 1'b1;
                mem_rdata <= peek(int'(mem_addr));
                if (mem_we) store[int'(mem_addr)] = mem_wdata;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end else begin
            lat_cnt <= lat_cfg;
        end
    end

    // ---------------- reference model state ----------------
    int ref_ptr = 0;
    bit ref_we  = 0;
    logic [7:0] ref_wdata = '0;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the memory port against the model (R3, R10)
    always @(negedge clk) begin
        if (!rst && !done_flag && mem_req) begin
            chk("R10 mem_addr follows pointer", int'(mem_addr), ref_ptr);
            chk("R3 mem_we", int'(mem_we), int'(ref_we));
            if (ref_we) chk("R3 mem_wdata", int'(mem_wdata), int'(ref_wdata));
        end
    end

    task automatic acc(input bit wr, input logic [2:0] a, input logic [7:0] d,
                       output logic [7:0] q, output int waits);
        if (a >= 3'd3 && a <= 3'd5) begin
            ref_we    = wr;
            ref_wdata = d;
        end
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = wr;
        bus_rd    = !wr;
        bus_wdata = d;
        #1;
        waits = 0;
        while (bus_wait) begin
            waits++;
            @(negedge clk);
            #1;
        end
        q = bus_rdata;
        @(posedge clk);
        #1;
        bus_rd = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] q; int w;
        acc(1'b1, a, d, q, w);
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] q);
        int w;
        acc(1'b0, a, 8'h00, q, w);
    endtask

    task automatic set_ptr(input int v);
        wr_reg(3'd0, 8'(v));
        wr_reg(3'd1, 8'(v >> 8));
        wr_reg(3'd2, 8'(v >> 16));
        ref_ptr = v & 32'h1FFFF;
    endtask

    task automatic get_ptr(output int v);
        logic [7:0] lo, mid, hi;
        rd_reg(3'd0, lo);
        rd_reg(3'd1, mid);
        rd_reg(3'd2, hi);
        v = {15'd0, hi[0], mid, lo};
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        logic [7:0] q;
        int w, p;

        repeat (3) @(posedge clk);
        #1;
        // R1: held in reset
        chk("R1 mem_req in reset", int'(mem_req), 0);
        chk("R1 bus_wait in reset", int'(bus_wait), 0);
        @(negedge clk);
        rst = 1'b0;
        get_ptr(p);
        chk("R1 pointer after reset", p, 0);

        // R2: pointer byte registers, high bits unimplemented
        wr_reg(3'd0, 8'h45);
        wr_reg(3'd1, 8'h23);
        wr_reg(3'd2, 8'hFF);
        ref_ptr = 32'h12345;
        rd_reg(3'd2, q);
        chk("R2 high register reads bit0 only", int'(q), 8'h01);
        get_ptr(p);
        chk("R2 pointer readback", p, 32'h12345);

        // R4, R5: stay alias read, latency sweep
        store[32'h12345] = 8'hA5;
        for (int lat = 0; lat < 4; lat++) begin
            lat_cfg = lat;
            @(negedge clk);
            acc(1'b0, 3'd3, 8'h00, q, w);
            chk("R4 read data", int'(q), 8'hA5);
            chk("R4 wait cycles", w, lat + 2);
        end
        lat_cfg = 1;
        get_ptr(p);
        chk("R5 stay alias keeps pointer", p, 32'h12345);

        // R3: stay alias write reaches memory at the pointer
        acc(1'b1, 3'd3, 8'h5A, q, w);
        chk("R3 write stored", int'(peek(32'h12345)), 8'h5A);
        get_ptr(p);
        chk("R5 pointer after stay write", p, 32'h12345);

        // R6: byte-step reads across consecutive addresses
        set_ptr(32'h000FE);
        for (int i = 0; i < 4; i++) begin
            acc(1'b0, 3'd4, 8'h00, q, w);
            chk("R6 sequential byte read", int'(q), int'(fill_byte(32'h000FE + i)));
            ref_ptr = ref_ptr + 1;
        end
        get_ptr(p);
        chk("R6 pointer advanced by four", p, 32'h00102);

        // R7: word-step pair with carry into the middle register
        lat_cfg = 0;
        set_ptr(32'h0AAFF);
        acc(1'b1, 3'd5, 8'h34, q, w);
        ref_ptr = ref_ptr + 1;
        get_ptr(p);
        chk("R7 carry into middle byte", p, 32'h0AB00);
        acc(1'b1, 3'd5, 8'h12, q, w);
        ref_ptr = ref_ptr + 1;
        chk("R7 first byte", int'(peek(32'h0AAFF)), 8'h34);
        chk("R7 second byte", int'(peek(32'h0AB00)), 8'h12);
        get_ptr(p);
        chk("R7 pointer after pair", p, 32'h0AB01);

        // R8: wrap on both stepping aliases, reading from another page
        set_ptr(32'h1FFFF);
        acc(1'b0, 3'd4, 8'h00, q, w);
        ref_ptr = 0;
        chk("R8 read at top address", int'(q), int'(fill_byte(32'h1FFFF)));
        get_ptr(p);
        chk("R8 byte-step wrap", p, 0);
        set_ptr(32'h1FFFF);
        acc(1'b1, 3'd5, 8'h77, q, w);
        ref_ptr = 0;
        chk("R8 write at top address", int'(peek(32'h1FFFF)), 8'h77);
        get_ptr(p);
        chk("R8 word-step wrap", p, 0);

        // R9: reserved offsets
        set_ptr(32'h05555);
        wr_reg(3'd6, 8'hFF);
        wr_reg(3'd7, 8'hAA);
        rd_reg(3'd6, q);
        chk("R9 offset 6 reads zero", int'(q), 0);
        rd_reg(3'd7, q);
        chk("R9 offset 7 reads zero", int'(q), 0);
        get_ptr(p);
        chk("R9 pointer untouched", p, 32'h05555);
        chk("R9 memory untouched", int'(peek(32'h05555)), int'(fill_byte(32'h05555)));
        chk("R9 no request pending", int'(mem_req), 0);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule